// File: doc/BRIEF.md
# Display Memory XY Address Stepper

This block keeps the column (X) and row (Y) address that a processor uses to reach the display memory of a dot-matrix LCD controller. Software sets both coordinates at once by writing one 8-bit, write-only value. After that, each processor access of the chosen kind (read or write) moves the address on automatically. Runs of data can therefore be streamed without rewriting the address for every byte.

Two traversal orders are available. In row-first order Y steps on every qualifying access and X steps when Y wraps. In column-first order X steps on every qualifying access and Y steps when X wraps. X covers columns 0 to 4. The top row for Y follows the duty setting: row 7 at 1/8 duty and row 15 at 1/16 duty. A flag reports when the loaded address lies outside the valid area.

Top module: `dispmem_addr_stepper`

## Requirements
- R1: A write (`wr_en`=1) loads X from `wr_data[7:5]` and Y from `wr_data[3:0]`. Bit 4 of the written byte has no effect. The new address appears on the outputs one cycle after the write.
- R2: While `rst_n` is low, X and Y are 0 and `addr_bad` is 0.
- R3: When `x_first`=0, a qualifying access increments Y. If Y was at or above the row maximum, Y becomes 0 instead and X advances by the X rule of R4.
- R4: When `x_first`=1, a qualifying access increments X. If X was 4 or more, X becomes 0 instead and Y advances by the Y rule of R3, wrapping to 0 when Y was at or above the row maximum.
- R5: The row maximum is 7 when `duty_eighth`=1 and 15 when `duty_eighth`=0.
- R6: An access qualifies only when `acc_valid`=1 and `acc_is_read` equals `adv_on_read` (`adv_on_read`=0 advances on writes, 1 advances on reads). Any other cycle without a register write leaves X and Y unchanged.
- R7: An access that carries out of both coordinates at their maximum (X=4 and Y at the row maximum) returns the address to (0,0), in either order.
- R8: When a register write and a qualifying access occur in the same cycle, the written values are loaded and the step is discarded.
- R9: `addr_bad` is 1 exactly when the current X is above 4 or the current Y is above the row maximum for the current `duty_eighth`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Written byte: X in bits 7:5, Y in bits 3:0 |
| acc_valid | input | 1 | Display memory access strobe |
| acc_is_read | input | 1 | Kind of the current access: 1 read, 0 write |
| adv_on_read | input | 1 | Access kind that advances: 1 read, 0 write |
| x_first | input | 1 | Order: 1 column-first, 0 row-first |
| duty_eighth | input | 1 | 1 selects 1/8 duty, 0 selects 1/16 duty |
| x_addr | output | 3 | Current column address |
| y_addr | output | 4 | Current row address |
| addr_bad | output | 1 | Current address lies outside the valid area |

## Verification
A write or a qualifying access that is sampled at a rising edge shows on `x_addr` and `y_addr` after that same edge. The result is therefore due one cycle after the stimulus is driven. `addr_bad` follows the registered address and `duty_eighth` combinationally, so it is due in the same cycle as the address it describes. The bench drives inputs on the falling edge and compares the outputs 2 ns after the next rising edge. The expected values come from a bench model that was stepped with the inputs in force at that edge.

// File: rtl/dispmem_addr_stepper.sv
module dispmem_addr_stepper #(
  parameter int DW = 8,
  parameter int XW = 3,
  parameter int YW = 4,
  parameter int X_LAST = 4,
  parameter int Y_LAST_SHORT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          acc_valid,
  input  logic          acc_is_read,
  input  logic          adv_on_read,
  input  logic          x_first,
  input  logic          duty_eighth,
  output logic [XW-1:0] x_addr,
  output logic [YW-1:0] y_addr,
  output logic          addr_bad
);

  localparam logic [XW-1:0] X_END = XW'(X_LAST);
  localparam logic [YW-1:0] Y_END_SHORT = YW'(Y_LAST_SHORT);
  localparam logic [YW-1:0] Y_END_FULL = '1;

  logic [XW-1:0] x_q, x_n, x_step;
  logic [YW-1:0] y_q, y_n, y_step, y_last;
  logic x_end, y_end, qual;

  assign y_last = duty_eighth ? Y_END_SHORT : Y_END_FULL;
  assign x_end  = x_q >= X_END;
  assign y_end  = y_q >= y_last;
  assign x_step = x_end ? '0 : x_q + XW'(1);
  assign y_step = y_end ? '0 : y_q + YW'(1);
  assign qual   = acc_valid && (acc_is_read == adv_on_read);

  always_comb begin
    x_n = x_q;
    y_n = y_q;
    if (wr_en) begin
      x_n = wr_data[DW-1 -: XW];
      y_n = wr_data[YW-1:0];
    end else if (qual) begin
      if (x_first) begin
        x_n = x_step;
        if (x_end) y_n = y_step;
      end else begin
        y_n = y_step;
        if (y_end) x_n = x_step;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_n;
      y_q <= y_n;
    end
  end

  assign x_addr   = x_q;
  assign y_addr   = y_q;
  assign addr_bad = (x_q > X_END) || (y_q > y_last);

  assert_write_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (x_addr == $past(wr_data[DW-1 -: XW])) && (y_addr == $past(wr_data[YW-1:0])));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(acc_valid && (acc_is_read == adv_on_read))) |=> ($stable(x_addr) && $stable(y_addr)));

  assert_col_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && qual && x_first && x_addr < X_END) |=> (x_addr == $past(x_addr) + XW'(1)) && $stable(y_addr));

  assert_row_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && qual && !x_first && y_addr < y_last) |=> (y_addr == $past(y_addr) + YW'(1)) && $stable(x_addr));

  assert_full_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && qual && x_addr == X_END && y_addr == y_last) |=> (x_addr == '0) && (y_addr == '0));

  assert_bad_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[DW-1 -: XW] > X_END) |=> addr_bad);

endmodule

// File: tb/dispmem_addr_stepper_tb_top.sv
module dispmem_addr_stepper_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic acc_valid = 1'b0, acc_is_read = 1'b0, adv_on_read = 1'b0;
  logic x_first = 1'b0, duty_eighth = 1'b0;
  logic [2:0] x_addr;
  logic [3:0] y_addr;
  logic addr_bad;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [2:0] mx = '0;
  logic [3:0] my = '0;

  always #4 clk = ~clk;

  dispmem_addr_stepper dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .acc_valid(acc_valid), .acc_is_read(acc_is_read), .adv_on_read(adv_on_read),
    .x_first(x_first), .duty_eighth(duty_eighth),
    .x_addr(x_addr), .y_addr(y_addr), .addr_bad(addr_bad)
  );

  function automatic logic [3:0] row_max(input logic d);
    return d ? 4'd7 : 4'd15;
  endfunction

  function automatic logic [6:0] model_next(input logic [2:0] x, input logic [3:0] y,
      input logic w, input logic [7:0] d, input logic av, input logic rd,
      input logic mode, input logic xf, input logic du);
    logic [2:0] xs;
    logic [3:0] ys;
    logic [2:0] nx;
    logic [3:0] ny;
    xs = (x >= 3'd4) ? 3'd0 : x + 3'd1;
    ys = (y >= row_max(du)) ? 4'd0 : y + 4'd1;
    nx = x;
    ny = y;
    if (w) begin
      nx = d[7:5];
      ny = d[3:0];
    end else if (av && (rd == mode)) begin
      if (xf) begin
        nx = xs;
        if (x >= 3'd4) ny = ys;
      end else begin
        ny = ys;
        if (y >= row_max(du)) nx = xs;
      end
    end
    return {nx, ny};
  endfunction

  task automatic check(input string tag);
    logic bad_exp;
    bad_exp = (mx > 3'd4) || (my > row_max(duty_eighth));
    checks++;
    if (x_addr !== mx || y_addr !== my || addr_bad !== bad_exp) begin
      errors++;
      $display("FAIL %s: got x=%0d y=%0d bad=%0b, expected x=%0d y=%0d bad=%0b",
               tag, x_addr, y_addr, addr_bad, mx, my, bad_exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic av, input logic rd,
      input logic mode, input logic xf, input logic du, input string tag);
    @(negedge clk);
    wr_en = w; wr_data = d; acc_valid = av; acc_is_read = rd;
    adv_on_read = mode; x_first = xf; duty_eighth = du;
    {mx, my} = model_next(mx, my, w, d, av, rd, mode, xf, du);
    @(posedge clk);
    #2;
    check(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    check("R2 reset");
    @(negedge clk);
    rst_n = 1'b1;

    step(1, 8'b011_1_0101, 0, 0, 0, 0, 1, "R1 load ignores bit 4");
    step(0, 8'h00, 1, 1, 0, 0, 1, "R6 read ignored when advancing on writes");
    step(0, 8'h00, 1, 0, 0, 0, 1, "R3 row step");
    step(0, 8'h00, 1, 0, 0, 0, 1, "R3 row step to 7");
    step(0, 8'h00, 1, 0, 0, 0, 1, "R3 R5 row wrap at 7 carries into X");
    step(1, 8'b100_0_0111, 0, 0, 0, 0, 1, "R1 load (4,7)");
    step(0, 8'h00, 1, 1, 1, 0, 1, "R7 full wrap row-first");
    step(1, 8'b100_0_1111, 0, 0, 0, 0, 0, "R1 load (4,15)");
    step(0, 8'h00, 1, 1, 1, 1, 0, "R7 R5 full wrap column-first 1/16");
    step(1, 8'b100_0_0010, 0, 0, 0, 1, 0, "R1 load (4,2)");
    step(0, 8'h00, 1, 0, 0, 1, 0, "R4 column wrap carries into Y");
    step(0, 8'h00, 1, 0, 0, 1, 0, "R4 column step");
    step(0, 8'h00, 0, 0, 0, 1, 0, "R6 no strobe holds");
    step(1, 8'b010_0_1001, 1, 0, 0, 1, 0, "R8 write wins over access");
    step(0, 8'h00, 0, 0, 0, 1, 1, "R9 row 9 invalid at 1/8 duty");
    step(0, 8'h00, 0, 0, 0, 1, 0, "R9 R5 row 9 valid at 1/16 duty");
    step(1, 8'b110_0_0000, 0, 0, 0, 0, 0, "R9 column 6 invalid");
    step(0, 8'h00, 1, 0, 0, 1, 0, "R4 column above 4 wraps");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[2:0] == 3'd0, r[15:8], r[4:3] != 2'b00, r[5], r[6], r[7], r[16],
           "R3 R4 R6 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule